// File: doc/BRIEF.md
# Serial Port Status Flag Controller

This block keeps the seven status flags of an asynchronous serial port and turns them into a status byte and one interrupt request. The transmitter reports two kinds of event. The first is a hand-off of the data register into the shift register. The second is a quiet shifter, meaning no data frame, preamble or break is in progress. The receiver reports five events: data ready, idle line, overrun, noise and framing error. Each event sets its flag.

A small register interface clears the flags. It has one select line, which picks the status or the data register, plus read and write strobes. A flag is never cleared by writing it. Clearing takes two steps: first a status read that returns the flag as 1, and then a later access to the data register. For the two transmit flags that access is a write. For the five receive flags it is a read. The interrupt output is asserted while any flag whose enable is 1 is set.

Top module: `serstat_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the status byte to 8'hC0, with both transmit flags at 1, all receive flags at 0 and no clearing sequence pending.
- R2: The status byte layout, from bit 7 down to bit 1, is: transmit-empty, transmit-complete, receive-full, idle, overrun, noise, framing. Bit 0 always reads 0. The enable input uses the same order on bits 6..0.
- R3: A one-cycle `tx_load` pulse makes transmit-empty (bit 7) read 1 from the next cycle on.
- R4: Transmit-complete (bit 6) becomes 1 the cycle after a cycle in which bit 7 is 1 and `tx_quiet` is 1.
- R5: Transmit-empty and transmit-complete clear in the cycle after a data-register write (`bus_sel`=1, `bus_wr`=1). This holds only if an earlier status read (`bus_sel`=0, `bus_rd`=1) saw the flag at 1.
- R6: The five receive flags clear in the cycle after a data-register read (`bus_sel`=1, `bus_rd`=1). This holds only if an earlier status read saw the flag at 1.
- R7: A data-register access leaves a flag unchanged if no status read has seen that flag at 1 since the last clear. A status read that returned the flag as 0 does not count.
- R8: A data-register read does not clear a transmit flag, and a data-register write does not clear a receive flag. Neither access cancels the other group's pending clear.
- R9: If a set event for a flag occurs in the same cycle as its clearing access, the flag stays 1, and a further clear needs a new status read.
- R10: A write to the status register address (`bus_sel`=0, `bus_wr`=1) changes no flag.
- R11: `irq_o` is 1 exactly when some flag is 1 and its enable bit in `irq_en` is 1, with no added cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register select: 0 status, 1 data |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| tx_load | input | 1 | Data register moved into transmit shift register |
| tx_quiet | input | 1 | Transmit shifter idle: no data, preamble or break |
| rx_full_evt | input | 1 | Received byte transferred to data register |
| rx_idle_evt | input | 1 | Receive line found idle |
| rx_ovr_evt | input | 1 | Receive overrun |
| rx_noise_evt | input | 1 | Noise detected in a received frame |
| rx_frame_evt | input | 1 | Framing error in a received frame |
| irq_en | input | 7 | Per-flag interrupt enables, order as in R2 |
| status_o | output | 8 | Status byte |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The clearing sequence is tried in several forms. The status read is followed by the correct data access, by the access of the wrong kind, and by an access with no arming read before it. It is also tried after a read that returned the flag as 0. Comparing these separates per-flag arming from arming on any status read, and separates write-clears from read-clears. Each receive event is pulsed on its own to pin down the bit layout. A set that coincides with the clearing access shows which of the two has priority. A run of status writes and enable patterns confirms that writes have no effect and that the interrupt gating works per source.

// File: rtl/serstat_pkg.sv
package serstat_pkg;

    localparam int NUM_FLAGS = 7;
    localparam int STAT_W    = NUM_FLAGS + 1;

    // flag index = status bit position minus one
    typedef enum logic [2:0] {
        FL_FRAME = 3'd0,
        FL_NOISE = 3'd1,
        FL_OVR   = 3'd2,
        FL_IDLE  = 3'd3,
        FL_RXF   = 3'd4,
        FL_TC    = 3'd5,
        FL_TDE   = 3'd6
    } flag_idx_e;

    typedef struct packed {
        logic stat_rd;
        logic data_rd;
        logic data_wr;
    } bus_evt_t;

    // transmit-side flags are cleared by a data write, the rest by a data read
    function automatic bit flag_is_tx(int idx);
        return (idx == int'(FL_TDE)) || (idx == int'(FL_TC));
    endfunction

    function automatic bit flag_rst_val(int idx);
        return flag_is_tx(idx);
    endfunction

endpackage

// File: rtl/serstat_bus_dec.sv
module serstat_bus_dec
    import serstat_pkg::*;
(
    input  logic     sel_i,
    input  logic     rd_i,
    input  logic     wr_i,
    output bus_evt_t evt_o
);

    // a status-address write produces no event at all
    always_comb begin
        evt_o         = '0;
        evt_o.stat_rd = rd_i & ~sel_i;
        evt_o.data_rd = rd_i &  sel_i;
        evt_o.data_wr = wr_i &  sel_i;
    end

endmodule

// File: rtl/serstat_flag_cell.sv
module serstat_flag_cell #(
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic arm_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;
    logic armed_q;
    logic clr_fire;

    assign clr_fire = armed_q & clr_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q  <= RST_VAL;
            armed_q <= 1'b0;
        end else begin
            if (set_i) begin
                flag_q <= 1'b1;
            end else if (clr_fire) begin
                flag_q <= 1'b0;
            end

            if (clr_fire) begin
                armed_q <= 1'b0;
            end else if (arm_i) begin
                armed_q <= flag_q;
            end
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/serstat_irq.sv
module serstat_irq #(
    parameter int N = 7
) (
    input  logic [N-1:0] flags_i,
    input  logic [N-1:0] en_i,
    output logic         irq_o
);

    assign irq_o = |(flags_i & en_i);

endmodule

// File: rtl/serstat_ctrl.sv
module serstat_ctrl
    import serstat_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic                 tx_load,
    input  logic                 tx_quiet,
    input  logic                 rx_full_evt,
    input  logic                 rx_idle_evt,
    input  logic                 rx_ovr_evt,
    input  logic                 rx_noise_evt,
    input  logic                 rx_frame_evt,
    input  logic [NUM_FLAGS-1:0] irq_en,
    output logic [STAT_W-1:0]    status_o,
    output logic                 irq_o
);

    bus_evt_t             evt;
    logic [NUM_FLAGS-1:0] flags;
    logic [NUM_FLAGS-1:0] set_vec;

    serstat_bus_dec u_dec (
        .sel_i (bus_sel),
        .rd_i  (bus_rd),
        .wr_i  (bus_wr),
        .evt_o (evt)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[FL_TDE]   = tx_load;
        set_vec[FL_TC]    = flags[FL_TDE] & tx_quiet;
        set_vec[FL_RXF]   = rx_full_evt;
        set_vec[FL_IDLE]  = rx_idle_evt;
        set_vec[FL_OVR]   = rx_ovr_evt;
        set_vec[FL_NOISE] = rx_noise_evt;
        set_vec[FL_FRAME] = rx_frame_evt;
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        logic clr_sel;
        if (flag_is_tx(g)) begin : g_tx
            assign clr_sel = evt.data_wr;
        end else begin : g_rx
            assign clr_sel = evt.data_rd;
        end

        serstat_flag_cell #(
            .RST_VAL (flag_rst_val(g))
        ) u_cell (
            .clk    (clk),
            .rst    (rst),
            .set_i  (set_vec[g]),
            .arm_i  (evt.stat_rd),
            .clr_i  (clr_sel),
            .flag_o (flags[g])
        );
    end

    serstat_irq #(
        .N (NUM_FLAGS)
    ) u_irq (
        .flags_i (flags),
        .en_i    (irq_en),
        .irq_o   (irq_o)
    );

    assign status_o = {flags, 1'b0};

endmodule

// File: rtl/serstat_ctrl_chk.sv
module serstat_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_sel,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic       tx_load,
    input logic       tx_quiet,
    input logic       rx_full_evt,
    input logic       rx_idle_evt,
    input logic       rx_ovr_evt,
    input logic       rx_noise_evt,
    input logic       rx_frame_evt,
    input logic [6:0] irq_en,
    input logic [7:0] status_o,
    input logic       irq_o
);

    logic any_evt;
    assign any_evt = tx_load | tx_quiet | rx_full_evt | rx_idle_evt |
                     rx_ovr_evt | rx_noise_evt | rx_frame_evt;

    p_bit0_zero_r2: assert property (@(posedge clk) disable iff (rst)
        status_o[0] == 1'b0);

    p_tde_set_r3: assert property (@(posedge clk) disable iff (rst)
        tx_load |=> status_o[7]);

    p_tc_set_r4: assert property (@(posedge clk) disable iff (rst)
        (status_o[7] && tx_quiet) |=> status_o[6]);

    p_tde_fall_needs_write_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(status_o[7]) |-> $past(bus_wr && bus_sel));

    p_rxf_fall_needs_read_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(status_o[5]) |-> $past(bus_rd && bus_sel));

    p_rx_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        rx_full_evt |=> status_o[5]);

    p_stat_wr_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_sel && !bus_rd && !any_evt) |=> $stable(status_o));

    p_irq_gate_r11: assert property (@(posedge clk) disable iff (rst)
        irq_o == (|(status_o[7:1] & irq_en)));

endmodule

bind serstat_ctrl serstat_ctrl_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .bus_sel      (bus_sel),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .tx_load      (tx_load),
    .tx_quiet     (tx_quiet),
    .rx_full_evt  (rx_full_evt),
    .rx_idle_evt  (rx_idle_evt),
    .rx_ovr_evt   (rx_ovr_evt),
    .rx_noise_evt (rx_noise_evt),
    .rx_frame_evt (rx_frame_evt),
    .irq_en       (irq_en),
    .status_o     (status_o),
    .irq_o        (irq_o)
);

// File: tb/serstat_ctrl_tb_top.sv
`timescale 1ns/1ps
module serstat_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic       tx_load = 1'b0, tx_quiet = 1'b0;
    logic       rx_full_evt = 1'b0, rx_idle_evt = 1'b0, rx_ovr_evt = 1'b0;
    logic       rx_noise_evt = 1'b0, rx_frame_evt = 1'b0;
    logic [6:0] irq_en = 7'h00;
    logic [7:0] status_o;
    logic       irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state: flags and pending-clear marks, bit 6 = status bit 7
    logic [6:0] mf = 7'b1100000;
    logic [6:0] ma = 7'b0000000;

    always #10 clk = ~clk;

    serstat_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .tx_load(tx_load), .tx_quiet(tx_quiet), .rx_full_evt(rx_full_evt),
        .rx_idle_evt(rx_idle_evt), .rx_ovr_evt(rx_ovr_evt),
        .rx_noise_evt(rx_noise_evt), .rx_frame_evt(rx_frame_evt),
        .irq_en(irq_en), .status_o(status_o), .irq_o(irq_o)
    );

    always @(posedge clk) begin : model
        logic [6:0] sv;
        logic [6:0] nf;
        logic [6:0] na;
        bit sr, dr, dw, clr;
        if (rst) begin
            mf = 7'b1100000;
            ma = 7'b0000000;
        end else begin
            sr = bus_rd && !bus_sel;
            dr = bus_rd && bus_sel;
            dw = bus_wr && bus_sel;
            sv = {tx_load, mf[6] && tx_quiet, rx_full_evt, rx_idle_evt,
                  rx_ovr_evt, rx_noise_evt, rx_frame_evt};
            for (int i = 0; i < 7; i++) begin
                clr = (i >= 5) ? dw : dr;
                if (sv[i]) nf[i] = 1'b1;
                else if (ma[i] && clr) nf[i] = 1'b0;
                else nf[i] = mf[i];
                if (ma[i] && clr) na[i] = 1'b0;
                else if (sr) na[i] = mf[i];
                else na[i] = ma[i];
            end
            mf = nf;
            ma = na;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (status_o !== {mf, 1'b0}) begin
                failures++;
                $display("FAIL R2 model status: actual=%h expected=%h", status_o, {mf, 1'b0});
            end
            checks++;
            if (irq_o !== (|(mf & irq_en))) begin
                failures++;
                $display("FAIL R11 model irq: actual=%b expected=%b", irq_o, |(mf & irq_en));
            end
        end
    end

    task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cycle();
        @(negedge clk);
        #2;
    endtask

    task automatic quiet_all();
        bus_sel = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
        tx_load = 1'b0; tx_quiet = 1'b0;
        rx_full_evt = 1'b0; rx_idle_evt = 1'b0; rx_ovr_evt = 1'b0;
        rx_noise_evt = 1'b0; rx_frame_evt = 1'b0;
    endtask

    task automatic stat_rd();
        bus_sel = 1'b0; bus_rd = 1'b1; cycle(); quiet_all();
    endtask

    task automatic stat_wr();
        bus_sel = 1'b0; bus_wr = 1'b1; cycle(); quiet_all();
    endtask

    task automatic data_rd();
        bus_sel = 1'b1; bus_rd = 1'b1; cycle(); quiet_all();
    endtask

    task automatic data_wr();
        bus_sel = 1'b1; bus_wr = 1'b1; cycle(); quiet_all();
    endtask

    initial begin : watchdog
        #(20 * 5000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        quiet_all();
        rst = 1'b1;
        repeat (3) cycle();
        rst = 1'b0;
        cycle();
        chk8("R1 reset value", status_o, 8'hC0);
        irq_en = 7'h40; cycle();
        chk8("R11 tde enabled", {7'b0, irq_o}, 8'h01);
        irq_en = 7'h1F; cycle();
        chk8("R11 rx enables only", {7'b0, irq_o}, 8'h00);
        irq_en = 7'h00;

        data_wr();
        chk8("R7 write without arming read", status_o, 8'hC0);
        stat_rd();
        data_rd();
        chk8("R8 data read keeps tx flags", status_o, 8'hC0);
        data_wr();
        chk8("R5 tx flags cleared by read then write", status_o, 8'h00);

        tx_load = 1'b1; cycle(); quiet_all();
        chk8("R3 tde set by load", status_o, 8'h80);
        tx_quiet = 1'b1; cycle(); quiet_all();
        chk8("R4 tc set when empty and quiet", status_o, 8'hC0);

        stat_rd();
        data_wr();
        chk8("R5 second clear", status_o, 8'h00);
        tx_load = 1'b1; cycle(); quiet_all();
        data_wr();
        chk8("R7 mark consumed by previous clear", status_o, 8'h80);

        rx_full_evt = 1'b1; cycle(); quiet_all();
        chk8("R2 receive-full at bit 5", status_o, 8'hA0);
        rx_idle_evt = 1'b1; cycle(); quiet_all();
        chk8("R2 idle at bit 4", status_o, 8'hB0);
        rx_ovr_evt = 1'b1; cycle(); quiet_all();
        chk8("R2 overrun at bit 3", status_o, 8'hB8);
        rx_noise_evt = 1'b1; cycle(); quiet_all();
        chk8("R2 noise at bit 2", status_o, 8'hBC);
        rx_frame_evt = 1'b1; cycle(); quiet_all();
        chk8("R2 framing at bit 1", status_o, 8'hBE);

        irq_en = 7'h04; cycle();
        chk8("R11 overrun enable", {7'b0, irq_o}, 8'h01);
        irq_en = 7'h00;

        stat_wr();
        stat_wr();
        chk8("R10 status write ignored", status_o, 8'hBE);

        stat_rd();
        data_wr();
        chk8("R8 data write keeps rx flags", status_o, 8'h3E);
        data_rd();
        chk8("R6 rx flags cleared by read then data read", status_o, 8'h00);

        stat_rd();
        rx_full_evt = 1'b1; cycle(); quiet_all();
        data_rd();
        chk8("R7 read that saw zero does not arm", status_o, 8'h20);

        stat_rd();
        bus_sel = 1'b1; bus_rd = 1'b1; rx_full_evt = 1'b1; cycle(); quiet_all();
        chk8("R9 set wins over clear", status_o, 8'h20);
        data_rd();
        chk8("R9 clear needs a new read", status_o, 8'h20);
        stat_rd();
        cycle();
        data_rd();
        chk8("R6 later access after gap", status_o, 8'h00);

        rst = 1'b1; cycle(); rst = 1'b0; cycle();
        chk8("R1 reset again", status_o, 8'hC0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule